// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps the rest of a chip in reset after power-on until the supply and the primary clock can be trusted. Once the power-on input goes away it walks through a short chain of timed stages. The stage set is chosen by two configuration inputs: an oscillator mode code and an active-low enable for a fixed power-up timer. The chain can hold three stages in order. The first is a fixed power-up wait on the slow timer clock. The second is a crystal start-up count of oscillator edges. The third is a PLL lock wait on the timer clock. Alongside the chain, a short controller-ready delay always runs from the same starting point.

The crystal count runs in the oscillator's own clock domain. A synchronized request goes to that domain and a synchronized completion comes back. The timer clock domain sees only single-bit, two-flop-synchronized signals.

The reset output is released only when the chain has finished and the ready delay has also finished. Raising the power-on input again at any time starts everything over. A second output reports that the primary oscillator is usable.

Top module: `pwrup_delay_seq`

## Requirements
- R1: While `por` is high, and on the first `clk` edge that samples it high, `core_rst` is driven to 1 and `osc_ready` to 0.
- R2: The ready delay counts `READY_CYC` `clk` edges from the first edge with `por` low. Take `osc_mode` 3'd0 (external clock) or 3'd1 (internal oscillator) with `pwrt_en_n`=1. Then `core_rst` is first low after exactly `READY_CYC`+1 edges.
- R3: With `pwrt_en_n`=0 a power-up stage of `PWRT_CYC` edges runs first. It runs concurrently with the ready delay, so in the modes of R2 `core_rst` is first low after max(`PWRT_CYC`,`READY_CYC`)+1 edges.
- R4: For `osc_mode` 3'd2 and 3'd3 (crystal modes), after the power-up stage (if any) `OST_CYC` rising edges of `osc_clk` are counted. Reset is released only after that count, plus the crossings of the two synchronizers, have been seen.
- R5: For `osc_mode` 3'd4 (crystal with PLL), a further `LOCK_CYC` `clk` edges are added after the crystal count. `core_rst` falls `LOCK_CYC`+1 edges after `osc_ready` rises.
- R6: `core_rst` is low only when the stage chain has finished and the ready delay has expired.
- R7: In crystal modes `osc_ready` rises on the edge the crystal count completion is accepted. In other modes it rises on the first edge after `por` falls. It stays high until `por` is raised.
- R8: Once low, `core_rst` stays low until `por` is raised again. Raising `por` at any point, even in the middle of a crystal count, restarts the complete sequence, including the crystal count.
- R9: `osc_mode` and `pwrt_en_n` are captured while `por` is high. Changes to them after `por` falls have no effect on `core_rst` or `osc_ready`.
- R10: Codes 3'd5 to 3'd7 of `osc_mode` behave as external clock (no crystal count, no lock wait).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-frequency timer clock |
| por | input | 1 | Power-on reset, active high, synchronous to `clk` |
| osc_clk | input | 1 | Primary oscillator clock used for the crystal count |
| osc_mode | input | 3 | Oscillator mode code (see R2, R4, R5, R10) |
| pwrt_en_n | input | 1 | Power-up timer enable, active low |
| core_rst | output | 1 | Reset to the rest of the chip, active high |
| osc_ready | output | 1 | Primary oscillator start-up complete |

## Verification
Every result is measured as the count of `clk` rising edges from the first edge that samples `por` low. The bench samples each output at the falling edge after each rising edge, so the first edge at which a change is seen gives the count directly. The external and internal modes have no clock crossing. For them the release is due at exactly `READY_CYC`+1 or `PWRT_CYC`+1 edges, and `osc_ready` at edge 1. These values are checked exactly. For crystal modes the two synchronizers add a few edges of uncertainty. The bench therefore accepts the release in a window around the oscillator count converted to timer cycles. It then checks the exact distance between the `osc_ready` rise and the release, which is 1 edge, or `LOCK_CYC`+1 edges with the PLL.

// File: rtl/pwrup_pkg.sv
`timescale 1ns/1ps
package pwrup_pkg;

    localparam logic [2:0] MODE_EXT   = 3'd0;
    localparam logic [2:0] MODE_INT   = 3'd1;
    localparam logic [2:0] MODE_XT    = 3'd2;
    localparam logic [2:0] MODE_HS    = 3'd3;
    localparam logic [2:0] MODE_HSPLL = 3'd4;

    typedef enum logic [1:0] {
        ST_PWRT = 2'd0,
        ST_OST  = 2'd1,
        ST_LOCK = 2'd2,
        ST_DONE = 2'd3
    } stage_e;

    typedef struct packed {
        logic pwrt_on;
        logic xtal;
        logic pll;
    } seq_cfg_t;

    function automatic seq_cfg_t decode_cfg(logic [2:0] mode, logic pwrt_en_n);
        seq_cfg_t c;
        c.pwrt_on = ~pwrt_en_n;
        c.xtal    = (mode == MODE_XT) || (mode == MODE_HS) || (mode == MODE_HSPLL);
        c.pll     = (mode == MODE_HSPLL);
        return c;
    endfunction

    function automatic stage_e stage_after(stage_e cur, seq_cfg_t c);
        case (cur)
            ST_PWRT: return c.xtal ? ST_OST : ST_DONE;
            ST_OST:  return c.pll ? ST_LOCK : ST_DONE;
            default: return ST_DONE;
        endcase
    endfunction

    function automatic stage_e first_stage(seq_cfg_t c);
        return c.pwrt_on ? ST_PWRT : stage_after(ST_PWRT, c);
    endfunction

endpackage

// File: rtl/pwrup_bit_sync.sv
`timescale 1ns/1ps
module pwrup_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pwrup_osc_counter.sv
`timescale 1ns/1ps
module pwrup_osc_counter #(
    parameter int OST_CYC     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic por,
    input  logic go,
    output logic done
);
    localparam int CW = $clog2(OST_CYC + 1);

    logic          osc_rst;
    logic          go_s;
    logic [CW-1:0] cnt;
    logic          done_q;

    pwrup_bit_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(osc_clk), .d(por), .q(osc_rst)
    );
    pwrup_bit_sync #(.STAGES(SYNC_STAGES)) u_go_sync (
        .clk(osc_clk), .d(go), .q(go_s)
    );

    always_ff @(posedge osc_clk) begin
        if (osc_rst || !go_s) begin
            cnt    <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt == CW'(OST_CYC - 1)) begin
                done_q <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = done_q;

    // R4: the crystal counter never runs past its terminal value
    a_r4_cnt_bound: assert property (@(posedge osc_clk) disable iff (osc_rst)
        cnt <= CW'(OST_CYC - 1));

    // R4: completion only while the synchronized request is present
    a_r4_done_needs_go: assert property (@(posedge osc_clk) disable iff (osc_rst)
        !go_s |=> !done_q);

endmodule

// File: rtl/pwrup_ready_timer.sv
`timescale 1ns/1ps
module pwrup_ready_timer #(
    parameter int READY_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int CW = $clog2(READY_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != CW'(READY_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == CW'(READY_CYC));

    // R2: ready counter saturates at its limit
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(READY_CYC));

    // R2: once expired it stays expired
    a_r2_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

endmodule

// File: rtl/pwrup_seq_fsm.sv
`timescale 1ns/1ps
module pwrup_seq_fsm
    import pwrup_pkg::*;
#(
    parameter int PWRT_CYC = 40,
    parameter int LOCK_CYC = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] osc_mode,
    input  logic       pwrt_en_n,
    input  logic       ost_done_s,
    output logic       ost_go,
    output logic       seq_done,
    output logic       osc_ok
);
    localparam int MAXC = (PWRT_CYC > LOCK_CYC) ? PWRT_CYC : LOCK_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_cfg_t      cfg_q;
    stage_e        st;
    logic [CW-1:0] cnt;
    logic          armed;
    logic          go_q;
    logic          ok_q;
    logic          ost_accept;

    assign ost_accept = (st == ST_OST) && armed && ost_done_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= decode_cfg(osc_mode, pwrt_en_n);
            st    <= first_stage(decode_cfg(osc_mode, pwrt_en_n));
            cnt   <= '0;
            armed <= 1'b0;
            go_q  <= 1'b0;
            ok_q  <= 1'b0;
        end else begin
            go_q <= (st == ST_OST);
            if (st == ST_OST && !ost_done_s) begin
                armed <= 1'b1;
            end
            if (!cfg_q.xtal || ost_accept) begin
                ok_q <= 1'b1;
            end
            case (st)
                ST_PWRT: begin
                    if (cnt == CW'(PWRT_CYC - 1)) begin
                        st  <= stage_after(ST_PWRT, cfg_q);
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_OST: begin
                    if (ost_accept) begin
                        st <= stage_after(ST_OST, cfg_q);
                    end
                end
                ST_LOCK: begin
                    if (cnt == CW'(LOCK_CYC - 1)) begin
                        st  <= ST_DONE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign ost_go   = go_q;
    assign seq_done = (st == ST_DONE);
    assign osc_ok   = ok_q;

    // R3: the power-up stage is entered only when enabled
    a_r3_pwrt_enabled: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PWRT) |-> cfg_q.pwrt_on);

    // R4: the crystal stage is used only in crystal modes
    a_r4_ost_only_xtal: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OST) |-> cfg_q.xtal);

    // R5: the lock stage is used only in the PLL mode
    a_r5_lock_only_pll: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOCK) |-> cfg_q.pll);

    // R8: the finished state is left only through reset
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE) |=> (st == ST_DONE));

    // R7: oscillator status, once set, holds until reset
    a_r7_ok_sticky: assert property (@(posedge clk) disable iff (rst)
        ok_q |=> ok_q);

endmodule

// File: rtl/pwrup_delay_seq.sv
`timescale 1ns/1ps
module pwrup_delay_seq #(
    parameter int PWRT_CYC    = 40,
    parameter int LOCK_CYC    = 30,
    parameter int READY_CYC   = 6,
    parameter int OST_CYC     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por,
    input  logic       osc_clk,
    input  logic [2:0] osc_mode,
    input  logic       pwrt_en_n,
    output logic       core_rst,
    output logic       osc_ready
);
    logic ost_go;
    logic ost_done_osc;
    logic ost_done_s;
    logic seq_done;
    logic rdy_done;
    logic osc_ok;
    logic rst_q;

    pwrup_seq_fsm #(.PWRT_CYC(PWRT_CYC), .LOCK_CYC(LOCK_CYC)) u_fsm (
        .clk(clk), .rst(por), .osc_mode(osc_mode), .pwrt_en_n(pwrt_en_n),
        .ost_done_s(ost_done_s), .ost_go(ost_go), .seq_done(seq_done),
        .osc_ok(osc_ok)
    );

    pwrup_ready_timer #(.READY_CYC(READY_CYC)) u_ready (
        .clk(clk), .rst(por), .done(rdy_done)
    );

    pwrup_osc_counter #(.OST_CYC(OST_CYC), .SYNC_STAGES(SYNC_STAGES)) u_ost (
        .osc_clk(osc_clk), .por(por), .go(ost_go), .done(ost_done_osc)
    );

    pwrup_bit_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(clk), .d(ost_done_osc), .q(ost_done_s)
    );

    always_ff @(posedge clk) begin
        if (por) begin
            rst_q <= 1'b1;
        end else begin
            rst_q <= ~(seq_done & rdy_done);
        end
    end

    assign core_rst  = rst_q;
    assign osc_ready = osc_ok;

    // R1: power-on forces reset on the following edge
    a_r1_hold_on_por: assert property (@(posedge clk)
        por |=> (core_rst && !osc_ready));

    // R6: release only with both the chain and the ready delay finished
    a_r6_release_gated: assert property (@(posedge clk) disable iff (por)
        !core_rst |-> (seq_done && rdy_done));

    // R8: once released, reset stays released until power-on
    a_r8_stays_low: assert property (@(posedge clk) disable iff (por)
        !core_rst |=> !core_rst);

endmodule

// File: tb/pwrup_delay_seq_tb.sv
`timescale 1ns/1ps
module pwrup_delay_seq_tb;

    localparam int PW  = 40;
    localparam int LK  = 30;
    localparam int RD  = 6;
    localparam int OST = 1024;
    localparam int CLK_PS = 10000;
    localparam int OSC_PS = 4000;
    localparam int XC  = (OST * OSC_PS) / CLK_PS;
    localparam int XLO = XC - 2;
    localparam int XHI = XC + 12;

    typedef struct packed {
        logic [2:0]  mode;
        logic        pwrt_n;
        logic [15:0] lo;
        logic [15:0] hi;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 16'(RD + 1),        16'(RD + 1)},
        '{3'd1, 1'b1, 16'(RD + 1),        16'(RD + 1)},
        '{3'd0, 1'b0, 16'(PW + 1),        16'(PW + 1)},
        '{3'd1, 1'b0, 16'(PW + 1),        16'(PW + 1)},
        '{3'd2, 1'b1, 16'(XLO),           16'(XHI)},
        '{3'd3, 1'b0, 16'(PW + XLO),      16'(PW + XHI)},
        '{3'd4, 1'b1, 16'(XLO + LK),      16'(XHI + LK)},
        '{3'd4, 1'b0, 16'(PW + XLO + LK), 16'(PW + XHI + LK)},
        '{3'd7, 1'b1, 16'(RD + 1),        16'(RD + 1)}
    };

    logic       clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       por = 1'b1;
    logic [2:0] osc_mode = 3'd0;
    logic       pwrt_en_n = 1'b1;
    logic       core_rst;
    logic       osc_ready;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;
    always #2 osc_clk = ~osc_clk;

    pwrup_delay_seq #(
        .PWRT_CYC(PW), .LOCK_CYC(LK), .READY_CYC(RD), .OST_CYC(OST), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .por(por), .osc_clk(osc_clk), .osc_mode(osc_mode),
        .pwrt_en_n(pwrt_en_n), .core_rst(core_rst), .osc_ready(osc_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_por(input logic [2:0] m, input logic pn);
        @(negedge clk);
        por = 1'b1;
        osc_mode = m;
        pwrt_en_n = pn;
        repeat (3) @(negedge clk);
        check(core_rst == 1'b1, "R1 core_rst during por", int'(core_rst), 1);
        check(osc_ready == 1'b0, "R1 osc_ready during por", int'(osc_ready), 0);
        por = 1'b0;
    endtask

    task automatic wait_release(input int flip_at, output int n_rst, output int n_osc);
        n_rst = 0;
        n_osc = 0;
        for (int k = 1; k <= 2000; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == flip_at) begin
                osc_mode = 3'd4;
                pwrt_en_n = 1'b0;
            end
            if (osc_ready && n_osc == 0) n_osc = k;
            if (!core_rst) begin
                n_rst = k;
                break;
            end
        end
    endtask

    initial begin
        int nr;
        int no;
        bit xt;
        int exp_osc;
        repeat (2) @(negedge clk);
        check(core_rst == 1'b1, "R1 initial core_rst", int'(core_rst), 1);

        for (int i = 0; i < NV; i++) begin
            apply_por(VECS[i].mode, VECS[i].pwrt_n);
            wait_release(0, nr, no);
            xt = (VECS[i].mode >= 3'd2) && (VECS[i].mode <= 3'd4);
            if (VECS[i].mode == 3'd4)
                check(nr >= int'(VECS[i].lo) && nr <= int'(VECS[i].hi),
                      "R5 pll release edge", nr, int'(VECS[i].lo));
            else if (xt)
                check(nr >= int'(VECS[i].lo) && nr <= int'(VECS[i].hi),
                      "R4 crystal release edge", nr, int'(VECS[i].lo));
            else if (VECS[i].mode == 3'd7)
                check(nr == int'(VECS[i].lo), "R10 unused code release", nr, int'(VECS[i].lo));
            else if (!VECS[i].pwrt_n)
                check(nr == int'(VECS[i].lo), "R3 power-up timer release", nr, int'(VECS[i].lo));
            else
                check(nr == int'(VECS[i].lo), "R2 ready-only release", nr, int'(VECS[i].lo));
            if (!xt) exp_osc = 1;
            else if (VECS[i].mode == 3'd4) exp_osc = nr - LK - 1;
            else exp_osc = nr - 1;
            check(no == exp_osc, "R7 osc_ready edge", no, exp_osc);
            check(nr > RD, "R6 release after ready delay", nr, RD + 1);
        end

        // R9: change configuration during a sequence
        apply_por(3'd0, 1'b1);
        wait_release(2, nr, no);
        check(nr == RD + 1, "R9 mid-sequence config change ignored", nr, RD + 1);
        // R8 and R9: stays released after configuration changes
        repeat (20) @(negedge clk);
        check(core_rst == 1'b0, "R8 stays released", int'(core_rst), 0);
        check(osc_ready == 1'b1, "R9 osc_ready unchanged", int'(osc_ready), 1);

        // R8: restart in the middle of a crystal count
        apply_por(3'd2, 1'b1);
        repeat (200) @(negedge clk);
        check(core_rst == 1'b1, "R8 still held mid-count", int'(core_rst), 1);
        apply_por(3'd2, 1'b1);
        wait_release(0, nr, no);
        check(nr >= XLO && nr <= XHI, "R8 restart repeats full crystal count", nr, XLO);
        check(no == nr - 1, "R8 restart osc_ready edge", no, nr - 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule